// File: doc/BRIEF.md
# USB Host Command and Run Control

This block holds the command word of a frame-schedule USB host controller and turns it into control for the rest of the host. Software starts and stops the schedule with a run bit. The block treats that bit as a handshake with the transaction engine. A transaction that is already on the bus is allowed to finish. The halted flag is raised only after that. The block also provides a single-step debug mode, global suspend with hardware-detected resume, a resume/EOP signalling sequence, a self-timed host-controller reset, and a software global reset.

The transaction engine sees a one-cycle start pulse and reports back with a done strobe. Fatal error strobes stop the schedule and latch a sticky error bit. Line-level signalling is requested through three drive outputs: resume, EOP and bus reset. The power-on reset input has the same effect as global reset, except that no bus reset is driven.

Top module: `uhc_runctl`

## Requirements
- R1: Command word layout is bit0 run, bit1 debug step, bit2 suspend, bit3 force resume, bit4 host reset, bit5 global reset. After power-on reset the word reads 0, halted reads 1, the sticky error reads 0, and no drive output or start pulse is active. Bus reset is not driven while the reset input is low.
- R2: Writing run=1 while halted clears halted in the next cycle. From then on, xfer_start is high in every cycle in which run is 1, the block is not halted, no transaction is in flight, and suspend is 0. The cycle with xfer_start high starts a transaction, and xfer_done ends it.
- R3: After run is written 0, halted stays 0 while a transaction is in flight. Halted rises in the cycle after the last xfer_done, or in the cycle after the write if nothing was in flight.
- R4: With debug step at 1, xfer_done clears run, and no new start follows until run is written 1 again. This hardware clear wins over a run write in the same cycle.
- R5: A consistency or host-bus error strobe clears run and sets err_sticky. err_clr clears err_sticky. When an error strobe and err_clr fall in the same cycle, the error wins. When an error strobe and a run write fall in the same cycle, the error also wins.
- R6: Writes to the debug step bit take effect only while halted is 1. At other times the bit keeps its value.
- R7: While suspend is 1, no transaction is started. A resume event while suspend is 1 sets force resume and pulses resume_irq in the next cycle. A resume event while suspend is 0 changes nothing.
- R8: drv_resume is high while force resume is 1 and no EOP is pending. Writing force resume 0 while it is 1 starts an EOP: drv_eop goes high and the bit keeps reading 1. At eop_done the bit and drv_eop both clear.
- R9: Writing host reset 1 aborts any in-flight transaction (xfer_abort is high in that cycle). The same write clears run, debug step, suspend and force resume, and sets halted. The host reset bit then reads 1 for exactly HRST_CYCLES cycles and clears itself. Other writes are ignored while it reads 1.
- R10: While global reset reads 1, drv_reset is high, every other command bit and err_sticky are held at 0, halted is 1, and writes change only the global reset bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 6 | Command word write value |
| err_clr | input | 1 | Write-1 clear of the sticky error bit |
| xfer_done | input | 1 | Transaction engine finished the current transaction |
| err_consist | input | 1 | Consistency-check failure strobe |
| err_hostbus | input | 1 | Host bus error strobe |
| resume_evt | input | 1 | Connect, disconnect or K-state detected on a port |
| eop_done | input | 1 | Low-speed EOP finished |
| cmd_rd | output | 6 | Command word readback |
| halted | output | 1 | Stopped status |
| err_sticky | output | 1 | Sticky fatal error status |
| xfer_start | output | 1 | Start pulse to the transaction engine |
| xfer_abort | output | 1 | In-flight transaction is killed this cycle |
| drv_resume | output | 1 | Request resume signalling on the bus |
| drv_eop | output | 1 | Request low-speed EOP on the bus |
| drv_reset | output | 1 | Request reset signalling on the bus |
| resume_irq | output | 1 | Resume interrupt pulse |

## Verification
Two collisions are provoked. The first is the debug-step stop, caused by xfer_done, landing in the same cycle as a software write of run=1. The bench expects run to read 0 afterwards and halted to follow one cycle later. The second is a fatal error strobe landing in the same cycle as the write-1 clear of the sticky bit. The bench sweeps every combination of the two error strobes, the clear, and the prior sticky value, and judges err_sticky against the arithmetic rule "set if any error, else old value unless cleared".

// File: rtl/uhc_rc_pkg.sv
package uhc_rc_pkg;
  localparam int CMD_W  = 6;
  localparam int B_RUN  = 0;
  localparam int B_STEP = 1;
  localparam int B_SUSP = 2;
  localparam int B_RSM  = 3;
  localparam int B_HRST = 4;
  localparam int B_GRST = 5;

  typedef struct packed {
    logic grst;
    logic hrst;
    logic rsm;
    logic susp;
    logic step;
    logic run;
  } cmd_t;

  // Sticky status rule: set has priority over the write-1 clear.
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/uhc_rc_reset.sv
module uhc_rc_reset #(
  parameter int HRST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_grst,
  input  logic wr_hrst,
  output logic grst_q,
  output logic hrst_q,
  output logic clr_hard,
  output logic clr_any
);
  localparam int CNT_W = $clog2(HRST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hrst_go;

  function automatic logic [CNT_W-1:0] cnt_dec(logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // Global reset write or held level clears everything at once.
  assign clr_hard = grst_q | (wr_en & wr_grst);
  assign hrst_go  = wr_en & wr_hrst & ~clr_hard & ~hrst_q;
  assign clr_any  = clr_hard | hrst_q | hrst_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grst_q <= 1'b0;
      hrst_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) grst_q <= wr_grst;
      if (clr_hard) begin
        hrst_q <= 1'b0;
        cnt_q  <= '0;
      end else if (hrst_go) begin
        hrst_q <= 1'b1;
        cnt_q  <= CNT_W'(HRST_CYCLES - 1);
      end else if (hrst_q) begin
        if (cnt_q == '0) hrst_q <= 1'b0;
        cnt_q <= cnt_dec(cnt_q);
      end
    end
  end

  assert_hrst_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hrst_q && cnt_q != '0 && !clr_hard) |=> hrst_q);
  assert_hrst_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hrst_q && cnt_q == '0 && !clr_hard) |=> !hrst_q);
endmodule

// File: rtl/uhc_rc_runstop.sv
module uhc_rc_runstop
  import uhc_rc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_any,
  input  logic clr_hard,
  input  logic wr_en,
  input  logic wr_run,
  input  logic wr_step,
  input  logic susp_q,
  input  logic xfer_done,
  input  logic err_consist,
  input  logic err_hostbus,
  input  logic err_clr,
  output logic run_q,
  output logic step_q,
  output logic halted_q,
  output logic busy_q,
  output logic err_q,
  output logic xfer_start
);
  logic fatal, step_done, hw_stop;
  logic run_d, step_d, halted_d, busy_d;

  assign fatal     = err_consist | err_hostbus;
  assign step_done = step_q & busy_q & xfer_done;
  assign hw_stop   = fatal | step_done;
  assign xfer_start = run_q & ~halted_q & ~busy_q & ~susp_q & ~clr_any;

  always_comb begin
    if (clr_any)      run_d = 1'b0;
    else if (hw_stop) run_d = 1'b0;
    else if (wr_en)   run_d = wr_run;
    else              run_d = run_q;

    if (clr_any)                step_d = 1'b0;
    else if (wr_en && halted_q) step_d = wr_step;
    else                        step_d = step_q;

    if (clr_any)                   busy_d = 1'b0;
    else if (busy_q && xfer_done)  busy_d = 1'b0;
    else if (xfer_start)           busy_d = 1'b1;
    else                           busy_d = busy_q;

    if (clr_any)       halted_d = 1'b1;
    else if (halted_q) halted_d = ~run_d;
    else               halted_d = ~run_q & ~busy_q & ~run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      step_q   <= 1'b0;
      busy_q   <= 1'b0;
      halted_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      run_q    <= run_d;
      step_q   <= step_d;
      busy_q   <= busy_d;
      halted_q <= halted_d;
      err_q    <= clr_hard ? 1'b0 : sticky_next(err_q, fatal, err_clr);
    end
  end

  assert_halt_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !clr_any) |=> !halted_q);
  assert_step_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && busy_q && xfer_done && !clr_any) |=> !run_q);
  assert_fatal_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_consist || err_hostbus) && !clr_hard) |=> (err_q && !run_q));
  assert_step_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !halted_q && !clr_any) |=> $stable(step_q));
endmodule

// File: rtl/uhc_rc_suspend.sv
module uhc_rc_suspend (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_any,
  input  logic wr_en,
  input  logic wr_susp,
  input  logic wr_rsm,
  input  logic resume_evt,
  input  logic eop_done,
  output logic susp_q,
  output logic rsm_q,
  output logic eop_q,
  output logic irq_q
);
  logic hw_rsm, sw_end;

  assign hw_rsm = susp_q & resume_evt;
  assign sw_end = wr_en & ~wr_rsm & rsm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
      rsm_q  <= 1'b0;
      eop_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= hw_rsm & ~clr_any;
      if (clr_any) begin
        susp_q <= 1'b0;
        rsm_q  <= 1'b0;
        eop_q  <= 1'b0;
      end else begin
        if (wr_en) susp_q <= wr_susp;
        if (eop_q) begin
          if (eop_done) begin
            rsm_q <= 1'b0;
            eop_q <= 1'b0;
          end
        end else if (sw_end) begin
          eop_q <= 1'b1;
        end else if (hw_rsm) begin
          rsm_q <= 1'b1;
        end else if (wr_en) begin
          rsm_q <= wr_rsm;
        end
      end
    end
  end

  assert_resume_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_q && resume_evt && !clr_any && !eop_q) |=> (rsm_q && irq_q));
  assert_rsm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_q && !eop_done && !clr_any) |=> (rsm_q && eop_q));
endmodule

// File: rtl/uhc_runctl.sv
module uhc_runctl
  import uhc_rc_pkg::*;
#(
  parameter int HRST_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             err_clr,
  input  logic             xfer_done,
  input  logic             err_consist,
  input  logic             err_hostbus,
  input  logic             resume_evt,
  input  logic             eop_done,
  output logic [CMD_W-1:0] cmd_rd,
  output logic             halted,
  output logic             err_sticky,
  output logic             xfer_start,
  output logic             xfer_abort,
  output logic             drv_resume,
  output logic             drv_eop,
  output logic             drv_reset,
  output logic             resume_irq
);
  logic grst_q, hrst_q, clr_hard, clr_any;
  logic run_q, step_q, halted_q, busy_q, err_q;
  logic susp_q, rsm_q, eop_q, irq_q;
  cmd_t cmd;

  uhc_rc_reset #(.HRST_CYCLES(HRST_CYCLES)) u_reset (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_grst  (wr_data[B_GRST]),
    .wr_hrst  (wr_data[B_HRST]),
    .grst_q   (grst_q),
    .hrst_q   (hrst_q),
    .clr_hard (clr_hard),
    .clr_any  (clr_any)
  );

  uhc_rc_runstop u_runstop (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_any     (clr_any),
    .clr_hard    (clr_hard),
    .wr_en       (wr_en),
    .wr_run      (wr_data[B_RUN]),
    .wr_step     (wr_data[B_STEP]),
    .susp_q      (susp_q),
    .xfer_done   (xfer_done),
    .err_consist (err_consist),
    .err_hostbus (err_hostbus),
    .err_clr     (err_clr),
    .run_q       (run_q),
    .step_q      (step_q),
    .halted_q    (halted_q),
    .busy_q      (busy_q),
    .err_q       (err_q),
    .xfer_start  (xfer_start)
  );

  uhc_rc_suspend u_suspend (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_any    (clr_any),
    .wr_en      (wr_en),
    .wr_susp    (wr_data[B_SUSP]),
    .wr_rsm     (wr_data[B_RSM]),
    .resume_evt (resume_evt),
    .eop_done   (eop_done),
    .susp_q     (susp_q),
    .rsm_q      (rsm_q),
    .eop_q      (eop_q),
    .irq_q      (irq_q)
  );

  always_comb begin
    cmd.grst = grst_q;
    cmd.hrst = hrst_q;
    cmd.rsm  = rsm_q;
    cmd.susp = susp_q;
    cmd.step = step_q;
    cmd.run  = run_q;
  end

  assign cmd_rd     = cmd;
  assign halted     = halted_q;
  assign err_sticky = err_q;
  assign xfer_abort = busy_q & clr_any;
  assign drv_resume = rsm_q & ~eop_q;
  assign drv_eop    = eop_q;
  assign drv_reset  = grst_q;
  assign resume_irq = irq_q;

  assert_no_go_susp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> !xfer_start);
  assert_grst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grst_q |-> (halted && !err_sticky && cmd_rd == CMD_W'(1 << B_GRST)));
endmodule

// File: tb/tb_uhc_runctl.sv
module tb_uhc_runctl;
  localparam int HRST_N = 8;
  localparam logic [5:0] RUN = 6'h01, STEP = 6'h02, SUSP = 6'h04,
                         RSM = 6'h08, HRST = 6'h10, GRST = 6'h20;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [5:0] wr_data;
  logic err_clr, xfer_done, err_consist, err_hostbus, resume_evt, eop_done;
  logic [5:0] cmd_rd;
  logic halted, err_sticky, xfer_start, xfer_abort;
  logic drv_resume, drv_eop, drv_reset, resume_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  uhc_runctl #(.HRST_CYCLES(HRST_N)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .err_clr(err_clr), .xfer_done(xfer_done), .err_consist(err_consist),
    .err_hostbus(err_hostbus), .resume_evt(resume_evt), .eop_done(eop_done),
    .cmd_rd(cmd_rd), .halted(halted), .err_sticky(err_sticky),
    .xfer_start(xfer_start), .xfer_abort(xfer_abort), .drv_resume(drv_resume),
    .drv_eop(drv_eop), .drv_reset(drv_reset), .resume_irq(resume_irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] d);
    wr_en = 1'b1;
    wr_data = d;
    tick();
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic done_pulse();
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; err_clr = 1'b0; xfer_done = 1'b0;
    err_consist = 1'b0; err_hostbus = 1'b0; resume_evt = 1'b0; eop_done = 1'b0;
    repeat (3) tick();
    chk("R1 no bus reset under chip reset", drv_reset, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 cmd after reset", cmd_rd, 0);
    chk("R1 halted after reset", halted, 1);
    chk("R1 err after reset", err_sticky, 0);
    chk("R1 drives idle", {drv_resume, drv_eop, drv_reset, xfer_start}, 0);

    // R2 run handshake
    wr(RUN);
    chk("R2 cmd run", cmd_rd, RUN);
    chk("R2 halted cleared", halted, 0);
    chk("R2 start", xfer_start, 1);
    tick();
    chk("R2 no start while busy", xfer_start, 0);
    done_pulse();
    chk("R2 start after done", xfer_start, 1);

    // R3 stop waits for in-flight transaction
    wr(0);
    chk("R3 run reads 0", cmd_rd, 0);
    chk("R3 not halted yet", halted, 0);
    repeat (3) tick();
    chk("R3 still busy", halted, 0);
    done_pulse();
    chk("R3 halted lags done", halted, 0);
    tick();
    chk("R3 halted", halted, 1);

    // R4 debug step
    wr(STEP);
    chk("R4 step set", cmd_rd, STEP);
    wr(STEP | RUN);
    chk("R4 start", xfer_start, 1);
    tick();
    done_pulse();
    chk("R4 run cleared by step", cmd_rd, STEP);
    tick();
    chk("R4 halted after step", halted, 1);
    repeat (2) tick();
    chk("R4 no further start", xfer_start, 0);
    wr(STEP | RUN);
    tick();
    xfer_done = 1'b1; wr_en = 1'b1; wr_data = STEP | RUN;
    tick();
    xfer_done = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R4 step clear beats run write", cmd_rd, STEP);
    tick();
    chk("R4 halted after collision", halted, 1);

    // R6 step writes locked while running
    wr(RUN);
    chk("R6 step written while halted", cmd_rd, RUN);
    tick();
    wr(RUN | STEP);
    chk("R6 step write ignored when running", cmd_rd, RUN);
    done_pulse();
    chk("R6 run survives done without step", cmd_rd, RUN);

    // R5 fatal errors
    err_consist = 1'b1;
    tick();
    err_consist = 1'b0;
    chk("R5 run cleared by error", cmd_rd, 0);
    chk("R5 sticky set", err_sticky, 1);
    done_pulse();
    tick();
    chk("R5 halted after error", halted, 1);
    wr_en = 1'b1; wr_data = RUN; err_hostbus = 1'b1;
    tick();
    wr_en = 1'b0; wr_data = '0; err_hostbus = 1'b0;
    chk("R5 error beats run write", cmd_rd, 0);
    chk("R5 stays halted", halted, 1);
    for (int pre = 0; pre < 2; pre++) begin
      for (int e = 0; e < 4; e++) begin
        for (int c = 0; c < 2; c++) begin
          if (pre == 1) err_consist = 1'b1; else err_clr = 1'b1;
          tick();
          err_consist = 1'b0; err_clr = 1'b0;
          err_consist = e[0]; err_hostbus = e[1]; err_clr = c[0];
          tick();
          err_consist = 1'b0; err_hostbus = 1'b0; err_clr = 1'b0;
          chk("R5 sticky sweep", err_sticky,
              ((e != 0) || (pre == 1 && c == 0)) ? 1 : 0);
        end
      end
    end
    err_clr = 1'b1; tick(); err_clr = 1'b0;

    // R7 suspend and resume detection
    resume_evt = 1'b1; tick(); resume_evt = 1'b0;
    chk("R7 resume ignored outside suspend", cmd_rd, 0);
    chk("R7 no irq outside suspend", resume_irq, 0);
    wr(SUSP);
    wr(SUSP | RUN);
    chk("R7 no start in suspend", xfer_start, 0);
    tick();
    chk("R7 still no start", xfer_start, 0);
    wr(SUSP);
    tick();
    resume_evt = 1'b1; tick(); resume_evt = 1'b0;
    chk("R7 resume sets bit", cmd_rd, SUSP | RSM);
    chk("R7 irq pulse", resume_irq, 1);
    tick();
    chk("R7 irq one cycle", resume_irq, 0);
    chk("R8 resume driven", drv_resume, 1);

    // R8 EOP sequence
    wr(SUSP);
    chk("R8 bit held during EOP", cmd_rd, SUSP | RSM);
    chk("R8 eop driven", drv_eop, 1);
    chk("R8 resume stopped", drv_resume, 0);
    repeat (3) tick();
    chk("R8 still held", cmd_rd, SUSP | RSM);
    eop_done = 1'b1; tick(); eop_done = 1'b0;
    chk("R8 cleared at eop_done", cmd_rd, SUSP);
    chk("R8 eop off", drv_eop, 0);
    wr(0);

    // R9 host reset
    wr(RUN);
    tick();
    wr_en = 1'b1; wr_data = HRST;
    #1;
    chk("R9 abort in flight", xfer_abort, 1);
    tick();
    wr_en = 1'b0; wr_data = '0;
    chk("R9 bits cleared", cmd_rd, HRST);
    chk("R9 halted", halted, 1);
    begin
      int n = 1;
      while (cmd_rd[4] && n < 100) begin
        tick();
        if (cmd_rd[4]) n++;
      end
      chk("R9 host reset length", n, HRST_N);
    end
    chk("R9 self clear", cmd_rd, 0);
    wr(HRST);
    wr(RUN | SUSP);
    chk("R9 writes ignored", cmd_rd, HRST);
    repeat (HRST_N) tick();
    chk("R9 done", cmd_rd, 0);

    // R10 global reset
    err_consist = 1'b1; tick(); err_consist = 1'b0;
    wr(SUSP);
    wr(GRST);
    chk("R10 only grst", cmd_rd, GRST);
    chk("R10 bus reset", drv_reset, 1);
    chk("R10 halted", halted, 1);
    chk("R10 err cleared", err_sticky, 0);
    wr(GRST | RUN | SUSP);
    chk("R10 writes ignored", cmd_rd, GRST);
    wr(0);
    chk("R10 released", cmd_rd, 0);
    chk("R10 bus reset off", drv_reset, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule